// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the mode state machine for one channel of a bus transceiver. The channel has three modes: fail-safe, normal and sleep. The controller takes power and supply status, the enable pin, the transmit level, and remote (bus) and local (pin) wake events. A wake detector upstream has already filtered these events into single-cycle digital strobes. From these inputs the controller chooses the current mode.

From the mode it drives the communication enable and the high-side inhibit switch control. It also drives the overrides on the data pins that the host microcontroller reads after a wake-up:
- The receive pin is pulled low to signal a wake request.
- The transmit pin gets a strong pull-down for a local wake and a weak one for a remote wake.

Edges on the enable pin are filtered in clock cycles. One delay applies to entry into normal mode and a separate delay applies to entry into sleep. Sleep entry is only accepted when the transmit line is recessive (high) at the moment enable falls.

Mode encoding on the `mode` port: 2'b00 fail-safe, 2'b01 normal, 2'b10 sleep.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset, and on the clock edge after any cycle in which `pwrOk` is low, the mode is fail-safe (2'b00). The wake request flag and the wake source flag are cleared, so `rxdLow` and `txdPdStrong` are 0.
- R2: From fail-safe, the mode becomes normal (2'b01) on the edge that samples `enIn` high for the NORM_DLY-th consecutive cycle, where each counted cycle also has `supplyOk` high. A low `enIn` before that point restarts the count. With `supplyOk` low, normal is never entered.
- R3: In normal mode, a sample of `enIn` low that follows a high sample while `txdIn` is 1 starts the sleep filter. The mode becomes sleep (2'b10) on the SLEEP_DLY-th consecutive low sample. If `enIn` returns high first, the mode stays normal. If `txdIn` was 0 at the falling sample, the mode stays normal however long `enIn` stays low.
- R4: In normal mode, a cycle with `supplyOk` low moves the mode to fail-safe on the next edge.
- R5: In sleep mode, a cycle with `wakeRemote` or `wakeLocal` high moves the mode to fail-safe on the next edge and sets the wake request flag. In sleep mode, `enIn` and `supplyOk` have no effect on the mode. Wake events in fail-safe or normal mode change neither the mode nor the flags.
- R6: `inhOn` is 1 in normal mode, equals `supplyOk` in fail-safe mode, and is 0 in sleep mode.
- R7: `commEn` is 1 only in normal mode. `rxdOe` is 0 (receive pin high-impedance) only in sleep mode.
- R8: `rxdLow` is 1 in fail-safe mode while the wake request flag is set and `enIn` is low.
- R9: `txdPdStrong` is 1 (strong pull-down) under the conditions of R8 when the wake came from the local pin. It is 0 (weak pull-down) when the wake came from the bus.
- R10: While `enIn` is high, `rxdLow` and `txdPdStrong` are 0 in that same cycle. Both flags are cleared at the edge that samples `enIn` high.
- R11: When remote and local wake events arrive in the same cycle, the wake source is recorded as local.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrOk | input | 1 | Supply present (power-up level reached) |
| supplyOk | input | 1 | Supply above undervoltage level |
| enIn | input | 1 | Enable pin level |
| txdIn | input | 1 | Transmit pin level (1 = recessive) |
| wakeRemote | input | 1 | Filtered bus wake event strobe |
| wakeLocal | input | 1 | Filtered local wake pin event strobe |
| mode | output | 2 | Current mode: 00 fail-safe, 01 normal, 10 sleep |
| commEn | output | 1 | Transmit/receive path enabled |
| inhOn | output | 1 | Inhibit high-side switch on |
| rxdOe | output | 1 | Receive pin driven (0 = high-impedance) |
| rxdLow | output | 1 | Receive pin forced low as wake request |
| txdPdStrong | output | 1 | Transmit pin strong pull-down (local wake source) |

## Verification
The wake source flag is the hardest state to reach from the ports. It can only be set from sleep mode, and sleep is only reachable by first passing the normal-entry filter, then a qualified enable fall and the full sleep-entry filter. The bench walks this whole path for each wake flavour: remote, local, and both together.

The enable pin must also clear the flags without ever entering normal. The bench therefore raises enable for one cycle and checks the outputs twice:
- Just after the raise, before any edge, to see the combinational mask.
- After the edge, with enable low again, to see that the flags themselves were cleared.

The filter boundaries are checked by sampling one cycle before and at the expected transition edge.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

  typedef enum logic [1:0] {
    MODE_FAILSAFE = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_SLEEP    = 2'b10
  } xmcMode_e;

  // strobes from the mode control to the flag datapath
  typedef struct packed {
    logic setWake;
    logic srcLocal;
    logic clrWake;
  } xmcStrobe_t;

endpackage

// File: rtl/xmc_dly_timer.sv
module xmc_dly_timer #(
  parameter int unsigned LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armIn,
  input  logic holdIn,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curCnt;
  logic             active;

  always_comb begin
    curCnt = running ? cnt : '0;
    active = armIn | (running & holdIn);
    expire = active && (curCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!active || expire) begin
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      running <= 1'b1;
      cnt     <= curCnt + 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= LAST));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && holdIn && !expire) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/xmc_datapath.sv
module xmc_datapath
  import xmc_pkg::*;
#(
  parameter int unsigned NORM_DLY  = 7,
  parameter int unsigned SLEEP_DLY = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  xmcMode_e   curMode,
  input  xmcStrobe_t strobe,
  input  logic       enIn,
  input  logic       txdIn,
  input  logic       pwrOk,
  input  logic       supplyOk,
  output logic       normalGo,
  output logic       sleepGo,
  output logic       commEn,
  output logic       inhOn,
  output logic       rxdOe,
  output logic       rxdLow,
  output logic       txdPdStrong
);
  logic isFs, isNorm, isSleep;
  logic prevEn;
  logic wakeReqQ, wakeLocQ;
  logic normArm, sleepArm, sleepHold;

  always_comb begin
    isFs    = (curMode == MODE_FAILSAFE);
    isNorm  = (curMode == MODE_NORMAL);
    isSleep = (curMode == MODE_SLEEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prevEn <= 1'b0;
    else        prevEn <= enIn;
  end

  always_comb begin
    normArm   = isFs & enIn & supplyOk & pwrOk;
    sleepArm  = isNorm & ~enIn & prevEn & txdIn;
    sleepHold = isNorm & ~enIn;
  end

  xmc_dly_timer #(.LIMIT(NORM_DLY)) normTmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .armIn  (normArm),
    .holdIn (normArm),
    .expire (normalGo)
  );

  xmc_dly_timer #(.LIMIT(SLEEP_DLY)) sleepTmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .armIn  (sleepArm),
    .holdIn (sleepHold),
    .expire (sleepGo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wakeReqQ <= 1'b0;
      wakeLocQ <= 1'b0;
    end else if (strobe.clrWake) begin
      wakeReqQ <= 1'b0;
      wakeLocQ <= 1'b0;
    end else if (strobe.setWake) begin
      wakeReqQ <= 1'b1;
      wakeLocQ <= strobe.srcLocal;
    end
  end

  always_comb begin
    commEn      = isNorm;
    inhOn       = isNorm | (isFs & supplyOk);
    rxdOe       = ~isSleep;
    rxdLow      = isFs & wakeReqQ & ~enIn;
    txdPdStrong = isFs & wakeReqQ & wakeLocQ & ~enIn;
  end

  // R10
  flags_clear_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isNorm |-> !wakeReqQ);

  // R9
  strong_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txdPdStrong |-> rxdLow);

  // R8
  rxd_low_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxdLow |-> (rxdOe && !commEn));

endmodule

// File: rtl/xmc_control.sv
module xmc_control
  import xmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrOk,
  input  logic       supplyOk,
  input  logic       enIn,
  input  logic       wakeRemote,
  input  logic       wakeLocal,
  input  logic       normalGo,
  input  logic       sleepGo,
  output xmcMode_e   curMode,
  output xmcStrobe_t strobe
);
  xmcMode_e nxtMode;
  logic     anyWake;

  always_comb begin
    anyWake = wakeRemote | wakeLocal;
    nxtMode = curMode;
    if (!pwrOk) begin
      nxtMode = MODE_FAILSAFE;
    end else begin
      unique case (curMode)
        MODE_FAILSAFE: if (normalGo) nxtMode = MODE_NORMAL;
        MODE_NORMAL: begin
          if (!supplyOk)    nxtMode = MODE_FAILSAFE;
          else if (sleepGo) nxtMode = MODE_SLEEP;
        end
        MODE_SLEEP:    if (anyWake) nxtMode = MODE_FAILSAFE;
        default:       nxtMode = MODE_FAILSAFE;
      endcase
    end
  end

  always_comb begin
    strobe.setWake  = pwrOk & (curMode == MODE_SLEEP) & anyWake;
    strobe.srcLocal = wakeLocal;
    strobe.clrWake  = ~pwrOk | (enIn & ~strobe.setWake);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) curMode <= MODE_FAILSAFE;
    else        curMode <= nxtMode;
  end

  // R1
  pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrOk |=> (curMode == MODE_FAILSAFE));

  // R2
  normal_from_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(curMode == MODE_NORMAL) |-> ($past(curMode) == MODE_FAILSAFE && $past(enIn)));

  // R3
  sleep_from_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(curMode == MODE_SLEEP) |-> ($past(curMode) == MODE_NORMAL && !$past(enIn)));

  // R4
  undervolt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrOk && !supplyOk && curMode == MODE_NORMAL) |=> (curMode == MODE_FAILSAFE));

  // R5
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrOk && curMode == MODE_SLEEP && (wakeRemote || wakeLocal)) |=> (curMode == MODE_FAILSAFE));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xmc_pkg::*;
#(
  parameter int unsigned NORM_DLY  = 7,
  parameter int unsigned SLEEP_DLY = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrOk,
  input  logic       supplyOk,
  input  logic       enIn,
  input  logic       txdIn,
  input  logic       wakeRemote,
  input  logic       wakeLocal,
  output logic [1:0] mode,
  output logic       commEn,
  output logic       inhOn,
  output logic       rxdOe,
  output logic       rxdLow,
  output logic       txdPdStrong
);
  xmcMode_e   curMode;
  xmcStrobe_t strobe;
  logic       normalGo, sleepGo;

  xmc_control ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrOk      (pwrOk),
    .supplyOk   (supplyOk),
    .enIn       (enIn),
    .wakeRemote (wakeRemote),
    .wakeLocal  (wakeLocal),
    .normalGo   (normalGo),
    .sleepGo    (sleepGo),
    .curMode    (curMode),
    .strobe     (strobe)
  );

  xmc_datapath #(.NORM_DLY(NORM_DLY), .SLEEP_DLY(SLEEP_DLY)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .curMode     (curMode),
    .strobe      (strobe),
    .enIn        (enIn),
    .txdIn       (txdIn),
    .pwrOk       (pwrOk),
    .supplyOk    (supplyOk),
    .normalGo    (normalGo),
    .sleepGo     (sleepGo),
    .commEn      (commEn),
    .inhOn       (inhOn),
    .rxdOe       (rxdOe),
    .rxdLow      (rxdLow),
    .txdPdStrong (txdPdStrong)
  );

  assign mode = curMode;

endmodule

// File: tb/xcvr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_tb_top;
  localparam int NDLY = 7;
  localparam int SDLY = 12;
  localparam logic [1:0] FS = 2'b00, NM = 2'b01, SL = 2'b10;

  logic clk = 1'b0;
  logic rst_n, pwrOk, supplyOk, enIn, txdIn, wakeRemote, wakeLocal;
  logic [1:0] mode;
  logic commEn, inhOn, rxdOe, rxdLow, txdPdStrong;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  xcvr_mode_ctrl #(.NORM_DLY(NDLY), .SLEEP_DLY(SDLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwrOk(pwrOk), .supplyOk(supplyOk),
    .enIn(enIn), .txdIn(txdIn), .wakeRemote(wakeRemote), .wakeLocal(wakeLocal),
    .mode(mode), .commEn(commEn), .inhOn(inhOn), .rxdOe(rxdOe),
    .rxdLow(rxdLow), .txdPdStrong(txdPdStrong)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic goNormal();
    enIn = 1'b1; step(NDLY);
    chk("R2 reach normal", mode, NM);
  endtask

  task automatic goSleep();
    txdIn = 1'b1;
    enIn = 1'b1; step(NDLY);
    enIn = 1'b0; step(SDLY);
    chk("R3 reach sleep", mode, SL);
  endtask

  task automatic clearFlags();
    enIn = 1'b1; step(1); enIn = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk("R1 reset mode", mode, FS);
    chk("R7 reset commEn", commEn, 0);
    chk("R6 reset inhOn", inhOn, 1);
    chk("R7 reset rxdOe", rxdOe, 1);
    chk("R1 reset rxdLow", rxdLow, 0);
    chk("R1 reset txdPdStrong", txdPdStrong, 0);
    supplyOk = 1'b0; #1;
    chk("R6 failsafe inh follows supply", inhOn, 0);
    step(1); supplyOk = 1'b1; step(1);
  endtask

  task automatic t_normal_entry();
    supplyOk = 1'b0; enIn = 1'b1; step(NDLY + 3);
    chk("R2 no normal without supply", mode, FS);
    supplyOk = 1'b1; enIn = 1'b0; step(1);
    enIn = 1'b1; step(NDLY - 2);
    enIn = 1'b0; step(1);
    chk("R2 interrupted filter", mode, FS);
    enIn = 1'b1; step(NDLY - 1);
    chk("R2 one short of delay", mode, FS);
    step(1);
    chk("R2 normal at delay", mode, NM);
    chk("R7 normal commEn", commEn, 1);
    chk("R6 normal inhOn", inhOn, 1);
  endtask

  task automatic t_sleep_entry();
    txdIn = 1'b0; enIn = 1'b0; step(SDLY + 5);
    chk("R3 fall with txd low keeps normal", mode, NM);
    enIn = 1'b1; step(1); txdIn = 1'b1; step(1);
    enIn = 1'b0; step(SDLY - 1);
    enIn = 1'b1; step(1);
    chk("R3 aborted sleep filter", mode, NM);
    step(2);
    enIn = 1'b0; step(SDLY - 1);
    chk("R3 one short of sleep delay", mode, NM);
    step(1);
    chk("R3 sleep at delay", mode, SL);
    chk("R6 sleep inhOn", inhOn, 0);
    chk("R7 sleep rxdOe", rxdOe, 0);
    chk("R7 sleep commEn", commEn, 0);
  endtask

  task automatic t_sleep_ignore();
    enIn = 1'b1; supplyOk = 1'b0; step(NDLY + 5);
    chk("R5 sleep ignores enable and supply", mode, SL);
    enIn = 1'b0; supplyOk = 1'b1; step(1);
  endtask

  task automatic t_wake_remote();
    wakeRemote = 1'b1; step(1); wakeRemote = 1'b0;
    chk("R5 remote wake to failsafe", mode, FS);
    chk("R8 remote wake request", rxdLow, 1);
    chk("R9 remote weak pull-down", txdPdStrong, 0);
    step(5);
    chk("R8 request held", rxdLow, 1);
    enIn = 1'b1; #1;
    chk("R10 enable masks request", rxdLow, 0);
    step(1); enIn = 1'b0; step(1);
    chk("R10 request cleared", rxdLow, 0);
    chk("R10 stays failsafe", mode, FS);
  endtask

  task automatic t_wake_local();
    goSleep();
    wakeLocal = 1'b1; step(1); wakeLocal = 1'b0;
    chk("R8 local wake request", rxdLow, 1);
    chk("R9 local strong pull-down", txdPdStrong, 1);
    enIn = 1'b1; #1;
    chk("R10 enable masks source", txdPdStrong, 0);
    step(1); enIn = 1'b0; step(1);
    chk("R10 source cleared", txdPdStrong, 0);
  endtask

  task automatic t_wake_both();
    goSleep();
    wakeLocal = 1'b1; wakeRemote = 1'b1; step(1);
    wakeLocal = 1'b0; wakeRemote = 1'b0;
    chk("R11 simultaneous wake gives local", txdPdStrong, 1);
    clearFlags();
  endtask

  task automatic t_wake_ignored();
    wakeRemote = 1'b1; step(1); wakeRemote = 1'b0;
    chk("R5 wake ignored in failsafe mode", mode, FS);
    chk("R5 wake ignored in failsafe flag", rxdLow, 0);
    goNormal();
    wakeLocal = 1'b1; step(1); wakeLocal = 1'b0;
    chk("R5 wake ignored in normal", mode, NM);
  endtask

  task automatic t_undervolt();
    supplyOk = 1'b0; step(1);
    chk("R4 undervoltage to failsafe", mode, FS);
    chk("R6 failsafe low supply inhOn", inhOn, 0);
    supplyOk = 1'b1; enIn = 1'b0; step(1);
  endtask

  task automatic t_pwr_loss();
    goSleep();
    wakeLocal = 1'b1; step(1); wakeLocal = 1'b0;
    pwrOk = 1'b0; step(1);
    chk("R1 power loss mode", mode, FS);
    chk("R1 power loss clears flags", rxdLow, 0);
    pwrOk = 1'b1; step(1);
    chk("R1 flags stay clear", txdPdStrong, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwrOk = 1'b1; supplyOk = 1'b1; enIn = 1'b0;
    txdIn = 1'b1; wakeRemote = 1'b0; wakeLocal = 1'b0;
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_normal_entry();
    t_sleep_entry();
    t_sleep_ignore();
    t_wake_remote();
    t_wake_local();
    t_wake_both();
    t_wake_ignored();
    t_undervolt();
    t_pwr_loss();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule